// File: doc/BRIEF.md
# Serial link frame synchronizer

This block locks onto the frame boundaries of a fixed-length serial audio link. A frame marker input is sampled on every falling edge of the bit clock. While the block is unlocked, the first high sample opens a frame. From then on, a bit counter steps once per bit and is split into a short tag slot followed by equal data slots. The serializer logic next to this block uses the position outputs to know which bit of which slot is on the wire.

A marker pulse that comes before the current frame has run its full length is ignored. The marker is checked for a new frame only on the last bit of a frame. When the marker is high there, the next frame follows directly. When it is low, the block drops lock and waits for the next high sample.

The block also keeps the link power-down flag. A one-cycle request input sets the flag. While the flag is set, the block tracks no frames. A high level on the marker input acts as a wake request. That request passes through a short synchronizer chain in the bit-clock domain and then clears the flag. After a wake, the marker must be seen low once before a high sample may open a frame. This keeps the tail of the wake pulse from being taken as a frame start.

Top module: `link_frame_sync`

## Requirements
- R1: While `rst_n` is low, and after it is released, `frame_valid` is 0, `link_pd` is 0, `bit_idx` is 0, and a low-to-high transition is not needed before the first frame.
- R2: While unlocked and powered up, the first falling edge that samples `sync_in` high makes `frame_valid` 1, `bit_idx` 0 and `frame_start` 1 right after that edge. Low samples leave `frame_valid` at 0.
- R3: While locked, `bit_idx` rises by one on each falling edge, up to FRAME_BITS-1.
- R4: A high `sync_in` sampled while `bit_idx` is below FRAME_BITS-1 has no effect on `bit_idx`, the slot outputs or `frame_valid`.
- R5: On the edge taken at `bit_idx` = FRAME_BITS-1, a high `sync_in` starts the next frame at `bit_idx` 0. A low `sync_in` makes `frame_valid` 0.
- R6: Slot 0 spans bit positions 0 to TAG_BITS-1. Slot k (k ≥ 1) spans SLOT_BITS bits starting at TAG_BITS+(k-1)·SLOT_BITS. `slot_bit` is the offset within the slot, and `slot_start` is 1 exactly when `slot_bit` is 0 within a frame. The last bit of a frame is the last bit of the last slot.
- R7: A high `pd_set` sampled on a falling edge makes `link_pd` 1 and `frame_valid` 0. While `link_pd` is 1, `frame_valid` stays 0 and `bit_idx` stays 0.
- R8: While `link_pd` is 1, a high `sync_in` sample clears `link_pd` WAKE_STAGES+1 falling edges later, counting the sampling edge as the first. A single high sample is enough. While `link_pd` is 0, `sync_in` never sets it.
- R9: After a wake, no frame opens until `sync_in` has been sampled low at least once. The first high sample after that opens a frame as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low cold reset |
| sync_in | input | 1 | Frame marker; also the wake request while powered down |
| pd_set | input | 1 | One-edge request to power the link down |
| frame_valid | output | 1 | High while locked to a frame |
| frame_start | output | 1 | High on bit 0 of a frame |
| bit_idx | output | clog2(FRAME_BITS) | Bit position within the frame |
| slot_idx | output | clog2(slot count) | Current slot number, 0 being the tag slot |
| slot_bit | output | clog2(max(TAG_BITS,SLOT_BITS)) | Bit offset within the current slot |
| slot_start | output | 1 | High on the first bit of each slot |
| link_pd | output | 1 | Link power-down flag |

## Verification
The bench builds the block with a 64-bit frame, a 4-bit tag slot and 6-bit data slots, which gives eleven slots. It keeps the wake chain at two stages. With the short frame, many whole frames fit in a short run. Every bit position, every slot boundary, the last-bit decision and mid-frame marker pulses are compared against a slot model written in the bench. The two-stage chain makes the three-edge wake latency exact, so it can be checked for both a held wake pulse and a single-sample wake pulse.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    // Number of slots in a frame: one tag slot plus the data slots.
    function automatic int slot_total(input int frame_bits, input int tag_bits,
                                      input int slot_bits);
        return 1 + (frame_bits - tag_bits) / slot_bits;
    endfunction

    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Counter width able to hold values 0 .. n-1, never below one bit.
    function automatic int width_of(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lfs_wake_sync.sv
module lfs_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic din,
    output logic seen
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = '0;
        if (enable) begin
            chain_d = {chain_q[STAGES-2:0], din};
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign seen = chain_q[STAGES-1];

    // R8: a chain left without enable reports nothing on the next edge
    assert_wake_cleared_R8: assert property (@(negedge clk) disable iff (!rst_n)
        !enable |=> !seen);

endmodule

// File: rtl/lfs_slot_track.sv
module lfs_slot_track #(
    parameter int TAG_BITS  = 16,
    parameter int SLOT_BITS = 20,
    parameter int NSLOT     = 13,
    parameter int SW        = 4,
    parameter int SBW       = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           advance,
    output logic [SW-1:0]  slot_idx,
    output logic [SBW-1:0] slot_bit
);
    typedef struct packed {
        logic [SW-1:0]  idx;
        logic [SBW-1:0] off;
    } slot_t;

    localparam logic [SBW-1:0] TAG_LAST  = SBW'(TAG_BITS - 1);
    localparam logic [SBW-1:0] SLOT_LAST = SBW'(SLOT_BITS - 1);

    slot_t sl_d, sl_q;
    logic [SBW-1:0] cur_last;

    always_comb begin
        cur_last = (sl_q.idx == '0) ? TAG_LAST : SLOT_LAST;
        sl_d     = '0;
        if (restart) begin
            sl_d = '0;
        end else if (advance) begin
            if (sl_q.off == cur_last) begin
                sl_d.idx = sl_q.idx + SW'(1);
                sl_d.off = '0;
            end else begin
                sl_d.idx = sl_q.idx;
                sl_d.off = sl_q.off + SBW'(1);
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) sl_q <= '0;
        else        sl_q <= sl_d;
    end

    assign slot_idx = sl_q.idx;
    assign slot_bit = sl_q.off;

    // R6: the tag slot never grows past its own length
    assert_tag_len_R6: assert property (@(negedge clk) disable iff (!rst_n)
        (slot_idx == '0) |-> (slot_bit <= TAG_LAST));

    // R6: the slot number stays within the frame
    assert_slot_range_R6: assert property (@(negedge clk) disable iff (!rst_n)
        slot_idx < SW'(NSLOT));

endmodule

// File: rtl/link_frame_sync.sv
module link_frame_sync
    import lfs_pkg::*;
#(
    parameter int FRAME_BITS  = 256,
    parameter int TAG_BITS    = 16,
    parameter int SLOT_BITS   = 20,
    parameter int WAKE_STAGES = 2
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pd_set,
    output logic frame_valid,
    output logic frame_start,
    output logic [width_of(FRAME_BITS)-1:0] bit_idx,
    output logic [width_of(slot_total(FRAME_BITS, TAG_BITS, SLOT_BITS))-1:0] slot_idx,
    output logic [width_of(wmax(TAG_BITS, SLOT_BITS))-1:0] slot_bit,
    output logic slot_start,
    output logic link_pd
);
    localparam int BW    = width_of(FRAME_BITS);
    localparam int NSLOT = slot_total(FRAME_BITS, TAG_BITS, SLOT_BITS);
    localparam int SW    = width_of(NSLOT);
    localparam int SBW   = width_of(wmax(TAG_BITS, SLOT_BITS));
    localparam logic [BW-1:0] LAST = BW'(FRAME_BITS - 1);

    typedef struct packed {
        logic          valid;
        logic          pd;
        logic          armed;
        logic [BW-1:0] pos;
    } fsm_t;

    localparam fsm_t RESET_ST = '{valid: 1'b0, pd: 1'b0, armed: 1'b1, pos: '0};

    fsm_t st_d, st_q;
    logic start_now, step_now, wake;

    lfs_wake_sync #(.STAGES(WAKE_STAGES)) u_wake (
        .clk    (bclk),
        .rst_n  (rst_n),
        .enable (st_q.pd),
        .din    (sync_in),
        .seen   (wake)
    );

    lfs_slot_track #(
        .TAG_BITS  (TAG_BITS),
        .SLOT_BITS (SLOT_BITS),
        .NSLOT     (NSLOT),
        .SW        (SW),
        .SBW       (SBW)
    ) u_slot (
        .clk      (bclk),
        .rst_n    (rst_n),
        .restart  (start_now),
        .advance  (step_now),
        .slot_idx (slot_idx),
        .slot_bit (slot_bit)
    );

    always_comb begin
        st_d      = st_q;
        start_now = 1'b0;
        step_now  = 1'b0;
        if (st_q.pd) begin
            st_d.valid = 1'b0;
            st_d.pos   = '0;
            if (wake) begin
                st_d.pd    = 1'b0;
                st_d.armed = 1'b0;
            end
        end else if (pd_set) begin
            st_d.pd    = 1'b1;
            st_d.valid = 1'b0;
            st_d.pos   = '0;
        end else begin
            if (!sync_in) st_d.armed = 1'b1;
            if (st_q.valid) begin
                if (st_q.pos == LAST) begin
                    st_d.pos = '0;
                    if (sync_in) start_now  = 1'b1;
                    else         st_d.valid = 1'b0;
                end else begin
                    st_d.pos = st_q.pos + BW'(1);
                    step_now = 1'b1;
                end
            end else if (sync_in && st_q.armed) begin
                st_d.valid = 1'b1;
                st_d.pos   = '0;
                start_now  = 1'b1;
            end
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign frame_valid = st_q.valid;
    assign bit_idx     = st_q.pos;
    assign link_pd     = st_q.pd;
    assign frame_start = st_q.valid && (st_q.pos == '0);
    assign slot_start  = st_q.valid && (slot_bit == '0);

    // R3 and R4: inside a frame the position only steps forward, whatever the marker does
    assert_count_step_R3: assert property (@(negedge bclk) disable iff (!rst_n)
        (frame_valid && !link_pd && !pd_set && bit_idx != LAST)
        |=> (frame_valid && bit_idx == $past(bit_idx) + BW'(1)));

    // R2: a frame only opens on an edge that sampled the marker high
    assert_start_needs_sync_R2: assert property (@(negedge bclk) disable iff (!rst_n)
        $rose(frame_valid) |-> $past(sync_in));

    // R5: a low marker on the last bit drops lock
    assert_lost_lock_R5: assert property (@(negedge bclk) disable iff (!rst_n)
        (frame_valid && bit_idx == LAST && !sync_in) |=> !frame_valid);

    // R6: the frame's last bit is the last bit of the last slot
    assert_slot_end_R6: assert property (@(negedge bclk) disable iff (!rst_n)
        (frame_valid && bit_idx == LAST)
        |-> (slot_idx == SW'(NSLOT - 1) && slot_bit == SBW'(SLOT_BITS - 1)));

    // R7: powered down means no frame
    assert_pd_blank_R7: assert property (@(negedge bclk) disable iff (!rst_n)
        link_pd |-> !frame_valid);

    // R9: waking never opens a frame on the same edge
    assert_wake_no_frame_R9: assert property (@(negedge bclk) disable iff (!rst_n)
        $fell(link_pd) |-> !frame_valid);

endmodule

// File: tb/link_frame_sync_test.sv
module link_frame_sync_test;
    localparam int N   = 64;
    localparam int TAG = 4;
    localparam int SL  = 6;
    localparam int NS  = 1 + (N - TAG) / SL;

    logic bclk = 1'b1;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic pd_set = 1'b0;
    logic frame_valid, frame_start, slot_start, link_pd;
    logic [5:0] bit_idx;
    logic [3:0] slot_idx;
    logic [2:0] slot_bit;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    link_frame_sync #(
        .FRAME_BITS(N), .TAG_BITS(TAG), .SLOT_BITS(SL), .WAKE_STAGES(2)
    ) uut (
        .bclk(bclk), .rst_n(rst_n), .sync_in(sync_in), .pd_set(pd_set),
        .frame_valid(frame_valid), .frame_start(frame_start), .bit_idx(bit_idx),
        .slot_idx(slot_idx), .slot_bit(slot_bit), .slot_start(slot_start),
        .link_pd(link_pd)
    );

    always #5 bclk = ~bclk;

    function automatic int exp_slot(input int b);
        return (b < TAG) ? 0 : 1 + (b - TAG) / SL;
    endfunction

    function automatic int exp_off(input int b);
        return (b < TAG) ? b : (b - TAG) % SL;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // one falling edge with the given inputs; outputs are read 1 ns after it
    task automatic tick(input logic s, input logic p);
        @(posedge bclk);
        sync_in = s;
        pd_set  = p;
        @(negedge bclk);
        #1;
    endtask

    task automatic check_pos(input int b, input string req);
        chk(req, "frame_valid", int'(frame_valid), 1);
        chk(req, "bit_idx", int'(bit_idx), b);
        chk("R6", "slot_idx", int'(slot_idx), exp_slot(b));
        chk("R6", "slot_bit", int'(slot_bit), exp_off(b));
        chk("R6", "slot_start", int'(slot_start), int'(exp_off(b) == 0));
        chk(req, "frame_start", int'(frame_start), int'(b == 0));
    endtask

    // bits 1..N-1 of a frame: marker high for bits 1..3, plus a stray pulse at glitch
    task automatic body(input int glitch);
        for (int b = 1; b < N; b++) begin
            tick((b < 4) || (b == glitch) || (b == glitch + 1), 1'b0);
            check_pos(b, (b == glitch || b == glitch + 1) ? "R4" : "R3");
        end
        chk("R8", "link_pd stays low in frames", int'(link_pd), 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b1);
        chk("R1", "frame_valid in reset", int'(frame_valid), 0);
        chk("R1", "link_pd in reset", int'(link_pd), 0);
        chk("R1", "bit_idx in reset", int'(bit_idx), 0);
        @(posedge bclk);
        sync_in = 1'b0;
        pd_set  = 1'b0;
        rst_n   = 1'b1;
        @(negedge bclk);
        #1;
        chk("R1", "frame_valid after release", int'(frame_valid), 0);
    endtask

    task automatic t_first_frame();
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b0);
            chk("R2", "no frame on low samples", int'(frame_valid), 0);
        end
        tick(1'b1, 1'b0);
        check_pos(0, "R2");
        body(20);
        tick(1'b1, 1'b0);
        check_pos(0, "R5");
    endtask

    task automatic t_late_glitch_and_loss();
        body(N - 3);
        tick(1'b0, 1'b0);
        chk("R5", "lock lost on low end marker", int'(frame_valid), 0);
        for (int i = 0; i < 5; i++) begin
            tick(1'b0, 1'b0);
            chk("R5", "stay unlocked", int'(frame_valid), 0);
        end
        tick(1'b1, 1'b0);
        check_pos(0, "R2");
    endtask

    task automatic t_powerdown_held_wake();
        for (int b = 1; b < 10; b++) begin
            tick(b < 4, 1'b0);
            check_pos(b, "R3");
        end
        tick(1'b0, 1'b1);
        chk("R7", "link_pd set", int'(link_pd), 1);
        chk("R7", "frame dropped", int'(frame_valid), 0);
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, 1'b0);
            chk("R7", "pd holds", int'(link_pd), 1);
            chk("R7", "no frame in pd", int'(frame_valid), 0);
            chk("R7", "bit_idx idle in pd", int'(bit_idx), 0);
        end
        tick(1'b1, 1'b0);
        chk("R8", "pd after wake edge 1", int'(link_pd), 1);
        tick(1'b1, 1'b0);
        chk("R8", "pd after wake edge 2", int'(link_pd), 1);
        tick(1'b1, 1'b0);
        chk("R8", "pd after wake edge 3", int'(link_pd), 0);
        chk("R9", "no frame on wake", int'(frame_valid), 0);
        for (int i = 0; i < 2; i++) begin
            tick(1'b1, 1'b0);
            chk("R9", "wake tail not a frame", int'(frame_valid), 0);
        end
        tick(1'b0, 1'b0);
        chk("R9", "still unlocked", int'(frame_valid), 0);
        tick(1'b1, 1'b0);
        check_pos(0, "R9");
        body(40);
    endtask

    task automatic t_short_wake();
        tick(1'b0, 1'b1);
        chk("R7", "link_pd set at frame end", int'(link_pd), 1);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        chk("R8", "pd after short pulse edge 2", int'(link_pd), 1);
        tick(1'b0, 1'b0);
        chk("R8", "short pulse wakes", int'(link_pd), 0);
        tick(1'b0, 1'b0);
        tick(1'b1, 1'b0);
        check_pos(0, "R9");
    endtask

    initial begin
        repeat (20000) @(posedge bclk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_frame();
        t_late_glitch_and_loss();
        t_powerdown_held_wake();
        t_short_wake();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule